// File: doc/BRIEF.md
# Receive tap-tracking edge controller

This block steers the sampling point of one bit lane of a source-synchronous receiver. Each clock cycle the lane delivers two data samples, one taken on each clock edge. It also delivers true/false sample pairs from an early guard tap and a late guard tap of a tapped delay line, again one pair per clock edge. The controller compares the guard samples with the data samples. From that it decides whether each guard tap sits inside the data eye, has drifted past an edge, or is locked on an edge. It then moves that tap one step toward more or less delay.

Single decisions are noisy, so each guard tap owns a random-walk filter. This is an up/down counter that starts at its midpoint. It fires an "up" after a net run of up decisions and a "down" after a net run of down decisions, and it jumps back to the midpoint whenever it fires. A fired filter steps the 4-bit address of its guard tap. The data tap address is the truncated mean of the two guard addresses. It is registered one cycle later, so a new data tap takes effect only on a cycle boundary.

An up decision needs proof that the serial stream actually toggled. The late side compares the rising-edge sample with the falling-edge sample of the same cycle. The early side compares the falling-edge sample of the previous cycle with the rising-edge sample of the current one.

Top module: `tap_track_ctrl`

## Requirements
- R1: After reset, early_tap reads 4, late_tap reads 11 and data_tap reads 7.
- R2: A late guard pattern that is locked (true samples equal the data samples on both edges, false samples differ on both edges) produces no late decision, and its filter state is unchanged.
- R3: When all four late guard samples equal their data samples and samp_rise differs from samp_fall, the late decision is up. With no such transition the pattern is ignored.
- R4: When all four late guard samples differ from their data samples, the late decision is down.
- R5: The early guard tap uses the same comparisons with the directions exchanged. All-differ is up. All-equal with an early transition is down.
- R6: The early transition is present when the previous cycle's samp_fall differs from the current samp_rise. samp_fall of the same cycle plays no part. Before the first cycle after reset the previous samp_fall is taken as 0.
- R7: Each filter starts at 32 on a 6-bit scale. It moves its tap up on the decision that brings it to 63, which is 31 net up decisions, and down on the decision that brings it to 0, which is 32 net down decisions. After either it restarts at 32.
- R8: A filter output steps its tap address by one in the edge where it fires. The address holds at 15 on up and at 0 on down.
- R9: data_tap equals floor((early_tap + late_tap) / 2) of the previous cycle. For example, early 10 and late 3 give 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_rise | input | 1 | Data tap sample taken on the rising edge |
| samp_fall | input | 1 | Data tap sample taken on the falling edge |
| late_rise_t | input | 1 | Late guard true sample, rising edge |
| late_rise_f | input | 1 | Late guard false sample, rising edge |
| late_fall_t | input | 1 | Late guard true sample, falling edge |
| late_fall_f | input | 1 | Late guard false sample, falling edge |
| early_rise_t | input | 1 | Early guard true sample, rising edge |
| early_rise_f | input | 1 | Early guard false sample, rising edge |
| early_fall_t | input | 1 | Early guard true sample, falling edge |
| early_fall_f | input | 1 | Early guard false sample, falling edge |
| early_tap | output | 4 | Early guard tap address |
| late_tap | output | 4 | Late guard tap address |
| data_tap | output | 4 | Data tap address |

## Verification
The filter hides every single decision, so the hard part is to prove that ignored patterns really leave it untouched. The patterns in question are locked patterns and all-equal patterns without a transition. The stimulus first parks a filter one step short of firing. It then plays long runs of the pattern under test, and it shows that exactly one further decision makes the tap move. The early transition is reached with samples that toggle between cycles but never within one cycle, which tells the previous-cycle rule apart from the same-cycle rule. An exhaustive sweep of all 1024 sample combinations, repeated from different filter states, is compared every cycle against an arithmetic model.

// File: rtl/tap_track_pkg.sv
package tap_track_pkg;
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DN   = 2'd2
  } move_t;
endpackage

// File: rtl/edge_judge.sv
module edge_judge
  import tap_track_pkg::*;
#(
  parameter bit EARLY = 1'b0
) (
  input  logic  d_rise,
  input  logic  d_fall,
  input  logic  g_rise_t,
  input  logic  g_rise_f,
  input  logic  g_fall_t,
  input  logic  g_fall_f,
  input  logic  toggled,
  output move_t mv
);
  logic all_eq;
  logic all_ne;
  logic want_more;
  logic want_less;

  always_comb begin
    all_eq = (g_rise_t == d_rise) && (g_rise_f == d_rise) &&
             (g_fall_t == d_fall) && (g_fall_f == d_fall);
    all_ne = (g_rise_t != d_rise) && (g_rise_f != d_rise) &&
             (g_fall_t != d_fall) && (g_fall_f != d_fall);
    // Guard fully inside the eye on the late side needs more delay.
    want_more = all_eq && toggled;
    want_less = all_ne;
    mv = MV_HOLD;
    if (EARLY) begin
      if (want_less)      mv = MV_UP;
      else if (want_more) mv = MV_DN;
    end else begin
      if (want_more)      mv = MV_UP;
      else if (want_less) mv = MV_DN;
    end
  end
endmodule

// File: rtl/walk_filter.sv
module walk_filter
  import tap_track_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic  clk,
  input  logic  rst_ni,
  input  move_t mv,
  output logic  fire_up,
  output logic  fire_dn
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [CW-1:0] MID  = {1'b1, {(CW-1){1'b0}}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    fire_up = 1'b0;
    fire_dn = 1'b0;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    if (mv == MV_UP) begin
      cnt_en = 1'b1;
      if (cnt_q == MAXV - ONE) begin
        fire_up = 1'b1;
        cnt_d   = MID;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (mv == MV_DN) begin
      cnt_en = 1'b1;
      if (cnt_q == ONE) begin
        fire_dn = 1'b1;
        cnt_d   = MID;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= MID;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: the counter recentres, so it never rests at either end
  a_r7_never_at_end: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q != '0) && (cnt_q != MAXV));

  // R7: each cycle it moves by one step or returns to the midpoint
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == MID) || (cnt_q == $past(cnt_q)) ||
             (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/guard_addr.sv
module guard_addr #(
  parameter int          AW   = 4,
  parameter logic [AW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          fire_up,
  input  logic          fire_dn,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr;
    if (fire_up && (addr != TOP)) begin
      addr_en = 1'b1;
      addr_d  = addr + ONE;
    end else if (fire_dn && (addr != '0)) begin
      addr_en = 1'b1;
      addr_d  = addr - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      addr <= INIT;
    else if (addr_en) addr <= addr_d;
  end

  // R8: no wrap from the top to the bottom or back
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> !(($past(addr) == TOP) && (addr == '0)) &&
             !(($past(addr) == '0) && (addr == TOP)));

  // R8: a change is always a single step
  a_r8_unit_step: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (addr == $past(addr)) || (addr == $past(addr) + ONE) ||
             (addr == $past(addr) - ONE));
endmodule

// File: rtl/tap_track_ctrl.sv
module tap_track_ctrl
  import tap_track_pkg::*;
#(
  parameter int            AW         = 4,
  parameter int            CW         = 6,
  parameter logic [AW-1:0] EARLY_INIT = 4'd4,
  parameter logic [AW-1:0] LATE_INIT  = 4'd11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_rise,
  input  logic          samp_fall,
  input  logic          late_rise_t,
  input  logic          late_rise_f,
  input  logic          late_fall_t,
  input  logic          late_fall_f,
  input  logic          early_rise_t,
  input  logic          early_rise_f,
  input  logic          early_fall_t,
  input  logic          early_fall_f,
  output logic [AW-1:0] early_tap,
  output logic [AW-1:0] late_tap,
  output logic [AW-1:0] data_tap
);
  localparam int NG = 2;  // index 0 = early guard, 1 = late guard

  logic [1:0]    rst_sync;
  logic          rst_i;
  logic          prev_fall;
  logic [NG-1:0] g_rt, g_rf, g_ft, g_ff, toggled, f_up, f_dn;
  move_t         mv [NG];
  logic [AW-1:0] tap [NG];
  logic [AW:0]   sum;
  logic [AW-1:0] data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) prev_fall <= 1'b0;
    else        prev_fall <= samp_fall;
  end

  always_comb begin
    g_rt    = {late_rise_t, early_rise_t};
    g_rf    = {late_rise_f, early_rise_f};
    g_ft    = {late_fall_t, early_fall_t};
    g_ff    = {late_fall_f, early_fall_f};
    toggled = {samp_rise ^ samp_fall, prev_fall ^ samp_rise};
  end

  for (genvar g = 0; g < NG; g++) begin : g_guard
    edge_judge #(.EARLY(g == 0)) u_judge (
      .d_rise   (samp_rise),
      .d_fall   (samp_fall),
      .g_rise_t (g_rt[g]),
      .g_rise_f (g_rf[g]),
      .g_fall_t (g_ft[g]),
      .g_fall_f (g_ff[g]),
      .toggled  (toggled[g]),
      .mv       (mv[g])
    );
    walk_filter #(.CW(CW)) u_filt (
      .clk     (clk),
      .rst_ni  (rst_i),
      .mv      (mv[g]),
      .fire_up (f_up[g]),
      .fire_dn (f_dn[g])
    );
    guard_addr #(.AW(AW), .INIT((g == 0) ? EARLY_INIT : LATE_INIT)) u_addr (
      .clk     (clk),
      .rst_ni  (rst_i),
      .fire_up (f_up[g]),
      .fire_dn (f_dn[g]),
      .addr    (tap[g])
    );
  end

  always_comb begin
    sum    = {1'b0, tap[0]} + {1'b0, tap[1]};
    data_d = sum[AW:1];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) data_tap <= AW'((({1'b0, EARLY_INIT} + {1'b0, LATE_INIT}) >> 1));
    else        data_tap <= data_d;
  end

  assign early_tap = tap[0];
  assign late_tap  = tap[1];

  // R2: a locked late pattern never moves the late tap
  a_r2_lock_holds: assert property (@(posedge clk) disable iff (!rst_i)
    (late_rise_t == samp_rise && late_rise_f != samp_rise &&
     late_fall_t == samp_fall && late_fall_f != samp_fall) |=> $stable(late_tap));

  // R3: all-equal without a transition never moves the late tap
  a_r3_no_toggle_no_move: assert property (@(posedge clk) disable iff (!rst_i)
    (samp_rise == samp_fall && late_rise_t == samp_rise && late_rise_f == samp_rise &&
     late_fall_t == samp_fall && late_fall_f == samp_fall) |=> $stable(late_tap));

  // R9: data tap follows the mean of the previous cycle's guard taps
  a_r9_data_mean: assert property (@(posedge clk) disable iff (!rst_i)
    1'b1 |=> ({1'b0, data_tap} == (({1'b0, $past(early_tap)} + {1'b0, $past(late_tap)}) >> 1)));
endmodule

// File: tb/tb_tap_track_ctrl.sv
module tb_tap_track_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic sr, sf, lrt, lrf, lft, lff, ert, erf, eft, eff;
  logic [3:0] early_tap, late_tap, data_tap;

  int n_cmp = 0;
  int n_bad = 0;
  int me, ml, md, ce, cl;
  bit mpf;

  always #2 clk = ~clk;

  tap_track_ctrl dut (
    .clk(clk), .rst_n(rst_n), .samp_rise(sr), .samp_fall(sf),
    .late_rise_t(lrt), .late_rise_f(lrf), .late_fall_t(lft), .late_fall_f(lff),
    .early_rise_t(ert), .early_rise_f(erf), .early_fall_t(eft), .early_fall_f(eff),
    .early_tap(early_tap), .late_tap(late_tap), .data_tap(data_tap)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kinds: 0 all equal, 1 all differ, 2 locked, 3 mixed
  function automatic logic [3:0] guard(input int k, input logic r, input logic f);
    case (k)
      0: guard = {r, r, f, f};
      1: guard = {~r, ~r, ~f, ~f};
      2: guard = {r, ~r, f, ~f};
      default: guard = {r, r, ~f, ~f};
    endcase
  endfunction

  task automatic filt(inout int c, inout int a, input int mv);
    if (mv == 1) begin
      if (c == 62) begin c = 32; if (a < 15) a++; end else c++;
    end else if (mv == -1) begin
      if (c == 1) begin c = 32; if (a > 0) a--; end else c--;
    end
  endtask

  task automatic tick_raw(input logic [9:0] v, input string tag);
    bit eq_l, ne_l, eq_e, ne_e;
    int lmv, emv, nd;
    {ert, erf, eft, eff, lrt, lrf, lft, lff, sf, sr} = v;
    @(posedge clk);
    nd   = (me + ml) / 2;
    eq_l = (lrt == sr) && (lrf == sr) && (lft == sf) && (lff == sf);
    ne_l = (lrt != sr) && (lrf != sr) && (lft != sf) && (lff != sf);
    eq_e = (ert == sr) && (erf == sr) && (eft == sf) && (eff == sf);
    ne_e = (ert != sr) && (erf != sr) && (eft != sf) && (eff != sf);
    lmv  = (eq_l && (sr != sf)) ? 1 : (ne_l ? -1 : 0);
    emv  = ne_e ? 1 : ((eq_e && (mpf != sr)) ? -1 : 0);
    filt(cl, ml, lmv);
    filt(ce, me, emv);
    mpf = sf;
    md  = nd;
    @(negedge clk);
    chk({tag, " early"}, early_tap, me);
    chk({tag, " late"}, late_tap, ml);
    chk({tag, " data"}, data_tap, md);
  endtask

  task automatic tick(input logic r, input logic f, input int ek, input int lk,
                      input int n, input string tag);
    for (int i = 0; i < n; i++)
      tick_raw({guard(ek, r, f), guard(lk, r, f), f, r}, tag);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ert, erf, eft, eff, lrt, lrf, lft, lff, sf, sr} = '0;
    me = 4; ml = 11; md = 7; ce = 32; cl = 32; mpf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset early", early_tap, 4);
    chk("R1 reset late", late_tap, 11);
    chk("R1 reset data", data_tap, 7);

    // R3 and R2: park the late filter one short, then ignored patterns
    tick(0, 1, 2, 0, 30, "R3 up run");
    chk("R3 30 ups no move", late_tap, 11);
    tick(0, 0, 2, 0, 40, "R3 no toggle");
    chk("R3 no-toggle ignored", late_tap, 11);
    tick(0, 1, 2, 2, 50, "R2 locked");
    chk("R2 locked ignored", late_tap, 11);
    tick(0, 1, 2, 3, 20, "R2 mixed");
    chk("R2 mixed ignored", late_tap, 11);
    tick(0, 1, 2, 0, 1, "R3 last up");
    chk("R3 late stepped up", late_tap, 12);
    // R7 recentre
    tick(0, 1, 2, 0, 30, "R7 refill");
    chk("R7 needs 31 again", late_tap, 12);
    tick(0, 1, 2, 0, 1, "R7 fire");
    chk("R7 second step", late_tap, 13);
    // R4 down needs 32
    tick(0, 1, 2, 1, 31, "R4 down run");
    chk("R4 31 downs no move", late_tap, 13);
    tick(0, 1, 2, 1, 1, "R4 fire");
    chk("R4 late stepped down", late_tap, 12);
    // R5 early swapped
    tick(0, 1, 1, 2, 30, "R5 early up run");
    chk("R5 early 30 no move", early_tap, 4);
    tick(0, 1, 1, 2, 1, "R5 early up fire");
    chk("R5 early stepped up", early_tap, 5);
    tick(0, 1, 0, 2, 31, "R5 early down run");
    chk("R5 early 31 downs", early_tap, 5);
    tick(0, 1, 0, 2, 1, "R5 early down fire");
    chk("R5 early stepped down", early_tap, 4);
    // R6 previous-cycle transition only
    for (int k = 0; k < 32; k++)
      tick(logic'(k % 2), logic'(k % 2), 0, 2, 1, "R6 cross-cycle toggle");
    chk("R6 early moved down", early_tap, 3);
    tick(1, 1, 0, 2, 40, "R6 steady");
    chk("R6 steady ignored", early_tap, 3);
    // R9 mean with lag and truncation
    tick(0, 1, 1, 2, 7 * 31 - 1, "R9 early climb");
    tick(0, 1, 1, 2, 1, "R9 early last");
    chk("R9 early at 10", early_tap, 10);
    chk("R9 data lags", data_tap, 10);
    tick(0, 1, 2, 2, 1, "R9 hold");
    chk("R9 data updated", data_tap, 11);
    tick(0, 1, 2, 1, 9 * 32, "R9 late drop");
    tick(0, 1, 2, 2, 1, "R9 hold");
    chk("R9 late at 3", late_tap, 3);
    chk("R9 trunc 10+3", data_tap, 6);
    tick(0, 1, 2, 1, 32, "R9 late drop");
    tick(0, 1, 2, 2, 1, "R9 hold");
    chk("R9 example 10+2", data_tap, 6);
    // R8 saturation
    tick(0, 1, 2, 1, 3 * 32, "R8 late floor");
    chk("R8 late floor", late_tap, 0);
    tick(0, 1, 1, 2, 6 * 31, "R8 early ceiling");
    chk("R8 early ceiling", early_tap, 15);
    // exhaustive sweep against the model
    for (int rep = 0; rep < 3; rep++)
      for (int v = 0; v < 1024; v++)
        tick_raw(10'(v ^ (rep * 341)), "sweep R3 R4 R5 R6 R8 R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule